// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is one DMA channel that takes its work order from memory. Software places three 32-bit words at a base address: a source address, a destination address and a transfer count. It sets the channel's arm bit, and from then on a peripheral request starts the channel. The channel requests the shared bus. Once the CPU grants it, the channel reads the three words, moves bytes from source to destination, writes the updated addresses and the remaining count back to the same words, and gives the bus back.

There are two modes. In burst mode one tenure moves the whole count, whatever the request line does after the start. In continuous mode the channel keeps moving bytes only while the request stays active. A tenure can therefore end with a nonzero count, and a later request resumes from the values that were written back. When the count reaches zero, the channel disarms itself and raises a sticky done flag, which can drive an interrupt line.

Top module: `dma_desc_channel`

## Requirements
- R1: After reset, bus_req, mem_valid, xfer_ack, xfer_end, chan_en, done and irq are all 0.
- R2: No bus request is made unless chan_en is 1 (set by an arm_set pulse) and the synchronized request is active. The request is active when req_in is high with req_active_low=0, and when req_in is low with req_active_low=1.
- R3: bus_req stays high from the request until the last write-back is accepted. mem_valid is high only while both bus_gnt and bus_req are high. When grant is removed the channel pauses with no access and then resumes where it stopped. An access with mem_ready low is held unchanged.
- R4: A tenure starts with three word reads at desc_base, desc_base+4 and desc_base+8, in that order, giving source, destination and count.
- R5: Each transfer is a byte read at the source address followed by a byte write of that data at the destination address. After each transfer each address steps by its 2-bit mode: 00 holds, 01 adds 1, 10 subtracts 1, 11 holds.
- R6: In burst mode (burst_mode=1) a tenure performs exactly as many transfers as the fetched count, even if the request is removed after the start.
- R7: In continuous mode (burst_mode=0) a further transfer starts only if the decremented count is nonzero and the request is still active. Otherwise the tenure goes to write-back with the remaining count.
- R8: xfer_ack is high on every byte access that completes. xfer_end is high, together with xfer_ack, only on the two accesses of the transfer that brings the count to zero.
- R9: Write-back is a word write of the current source to desc_base, present only if the source mode steps, then the current destination to desc_base+4, present only if the destination mode steps, then always the remaining count to desc_base+8. After that bus_req falls.
- R10: A tenure that ends with count zero sets done and clears chan_en. One that ends with count nonzero changes neither. done holds until a done_clr pulse, and irq equals done gated by irq_en.
- R11: A fetched count of zero causes no byte transfer: the channel goes straight to write-back of the unchanged values and finishes as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_set | input | 1 | Pulse that sets the channel enable |
| done_clr | input | 1 | Pulse that clears the done flag (write-one-to-clear) |
| burst_mode | input | 1 | 1 = burst, 0 = continuous |
| req_active_low | input | 1 | Selects low-level detection of req_in |
| irq_en | input | 1 | Lets done drive irq |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| desc_base | input | AW | Byte address of the descriptor |
| req_in | input | 1 | Asynchronous peripheral transfer request |
| bus_req | output | 1 | Bus ownership request to the CPU |
| bus_gnt | input | 1 | Bus ownership grant from the CPU |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access, 0 = word access |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | DW | Write data (byte in bits 7:0) |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| xfer_ack | output | 1 | Data transfer in progress |
| xfer_end | output | 1 | Final transfer of the count |
| chan_en | output | 1 | Channel armed |
| done | output | 1 | Sticky count-exhausted flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the bus-ownership rules on every cycle. They confirm that no access occurs without grant and request, that a stalled access holds its address, that xfer_end only appears inside a byte transfer, that a request can only rise while the channel is armed, that done can only rise as the channel disarms, and that bus_req only falls right after the count write-back. The order and content of the accesses can only be shown by the bench's scenarios. These cover the descriptor fetch order, the data moved and its address stepping per mode, the choice of write-backs, the number of transfers in burst mode, and continuous mode stopping when the request is removed and resuming later from the written-back state.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ASK,
    ST_GET_SRC,
    ST_GET_DST,
    ST_GET_CNT,
    ST_MOVE_RD,
    ST_MOVE_WR,
    ST_PUT_SRC,
    ST_PUT_DST,
    ST_PUT_CNT,
    ST_DROP
  } dma_state_e;

  localparam logic [1:0] AM_HOLD = 2'b00;
  localparam logic [1:0] AM_UP   = 2'b01;
  localparam logic [1:0] AM_DOWN = 2'b10;

  // An address that changes during a tenure needs its own write-back word.
  function automatic logic am_moves(input logic [1:0] m);
    return (m == AM_UP) || (m == AM_DOWN);
  endfunction

  // First write-back state, skipping addresses that never move.
  function automatic dma_state_e first_put(input logic src_mv, input logic dst_mv);
    if (src_mv)      return ST_PUT_SRC;
    else if (dst_mv) return ST_PUT_DST;
    else             return ST_PUT_CNT;
  endfunction

  function automatic dma_state_e after_src_put(input logic dst_mv);
    return dst_mv ? ST_PUT_DST : ST_PUT_CNT;
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic active_low,
  output logic level
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign level = sh_q[STAGES-1] ^ active_low;
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [1:0]    mode,
  output logic [AW-1:0] addr,
  output logic          moves
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_val;
    end else if (step) begin
      unique case (mode)
        AM_UP:   addr_q <= addr_q + AW'(1);
        AM_DOWN: addr_q <= addr_q - AW'(1);
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign addr  = addr_q;
  assign moves = am_moves(mode);
endmodule

// File: rtl/dma_desc_channel.sv
module dma_desc_channel
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_set,
  input  logic          done_clr,
  input  logic          burst_mode,
  input  logic          req_active_low,
  input  logic          irq_en,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [AW-1:0] desc_base,
  input  logic          req_in,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          xfer_ack,
  output logic          xfer_end,
  output logic          chan_en,
  output logic          done,
  output logic          irq
);
  localparam int unsigned WORD_B = DW / 8;
  localparam logic [AW-1:0] OFS_DST = AW'(WORD_B);
  localparam logic [AW-1:0] OFS_CNT = AW'(2 * WORD_B);

  dma_state_e    state_q, state_d;
  logic          req_lvl;
  logic          en_q, done_q;
  logic [CW-1:0] cnt_q, cnt_after, cnt_fetched;
  logic [7:0]    byte_q;
  logic [AW-1:0] src_addr, dst_addr;
  logic          src_moves, dst_moves;

  // Named internal events
  logic on_bus, hs;
  logic get_src_hs, get_cnt_hs, rd_hs, wr_hs, put_cnt_hs;
  logic keep_moving, tenure_drop, ends_empty;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (req_in),
    .active_low(req_active_low),
    .level     (req_lvl)
  );

  dma_addr_reg #(.AW(AW)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (get_src_hs),
    .load_val(mem_rdata[AW-1:0]),
    .step    (wr_hs),
    .mode    (src_mode),
    .addr    (src_addr),
    .moves   (src_moves)
  );

  dma_addr_reg #(.AW(AW)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state_q == ST_GET_DST && hs),
    .load_val(mem_rdata[AW-1:0]),
    .step    (wr_hs),
    .mode    (dst_mode),
    .addr    (dst_addr),
    .moves   (dst_moves)
  );

  always_comb begin
    unique case (state_q)
      ST_GET_SRC, ST_GET_DST, ST_GET_CNT, ST_MOVE_RD, ST_MOVE_WR,
      ST_PUT_SRC, ST_PUT_DST, ST_PUT_CNT: on_bus = 1'b1;
      default:                            on_bus = 1'b0;
    endcase
  end

  assign bus_req     = on_bus || (state_q == ST_ASK);
  assign mem_valid   = on_bus && bus_gnt;
  assign hs          = mem_valid && mem_ready;
  assign get_src_hs  = hs && (state_q == ST_GET_SRC);
  assign get_cnt_hs  = hs && (state_q == ST_GET_CNT);
  assign rd_hs       = hs && (state_q == ST_MOVE_RD);
  assign wr_hs       = hs && (state_q == ST_MOVE_WR);
  assign put_cnt_hs  = hs && (state_q == ST_PUT_CNT);
  assign cnt_fetched = mem_rdata[CW-1:0];
  assign cnt_after   = cnt_q - CW'(1);
  assign keep_moving = (cnt_after != '0) && (burst_mode || req_lvl);
  assign tenure_drop = (state_q == ST_DROP);
  assign ends_empty  = tenure_drop && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (en_q && req_lvl) state_d = ST_ASK;
      ST_ASK:     if (bus_gnt)         state_d = ST_GET_SRC;
      ST_GET_SRC: if (hs)              state_d = ST_GET_DST;
      ST_GET_DST: if (hs)              state_d = ST_GET_CNT;
      ST_GET_CNT: if (hs) state_d = (cnt_fetched == '0) ?
                                    first_put(src_moves, dst_moves) : ST_MOVE_RD;
      ST_MOVE_RD: if (hs)              state_d = ST_MOVE_WR;
      ST_MOVE_WR: if (hs) state_d = keep_moving ?
                                    ST_MOVE_RD : first_put(src_moves, dst_moves);
      ST_PUT_SRC: if (hs)              state_d = after_src_put(dst_moves);
      ST_PUT_DST: if (hs)              state_d = ST_PUT_CNT;
      ST_PUT_CNT: if (hs)              state_d = ST_DROP;
      ST_DROP:                         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (get_cnt_hs)  cnt_q  <= cnt_fetched;
      else if (wr_hs)  cnt_q  <= cnt_after;
      if (rd_hs)       byte_q <= mem_rdata[7:0];
      if (ends_empty)    en_q <= 1'b0;
      else if (arm_set)  en_q <= 1'b1;
      if (ends_empty)    done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_GET_SRC: mem_addr = desc_base;
      ST_GET_DST: mem_addr = desc_base + OFS_DST;
      ST_GET_CNT: mem_addr = desc_base + OFS_CNT;
      ST_MOVE_RD: begin
        mem_byte = 1'b1;
        mem_addr = src_addr;
      end
      ST_MOVE_WR: begin
        mem_byte  = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr;
        mem_wdata = DW'(byte_q);
      end
      ST_PUT_SRC: begin
        mem_we    = 1'b1;
        mem_addr  = desc_base;
        mem_wdata = DW'(src_addr);
      end
      ST_PUT_DST: begin
        mem_we    = 1'b1;
        mem_addr  = desc_base + OFS_DST;
        mem_wdata = DW'(dst_addr);
      end
      ST_PUT_CNT: begin
        mem_we    = 1'b1;
        mem_addr  = desc_base + OFS_CNT;
        mem_wdata = DW'(cnt_q);
      end
      default: ;
    endcase
  end

  assign xfer_ack = mem_valid && mem_byte;
  assign xfer_end = xfer_ack && (cnt_q == CW'(1));
  assign chan_en  = en_q;
  assign done     = done_q;
  assign irq      = done_q && irq_en;
endmodule

// File: rtl/dma_desc_channel_chk.sv
module dma_desc_channel_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_byte,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_ack,
  input logic          xfer_end,
  input logic          chan_en,
  input logic          done,
  input logic          put_cnt_hs
);
  a_r3_access_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_gnt);

  a_r3_access_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (!bus_gnt || (mem_valid && $stable(mem_addr))));

  a_r2_req_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> chan_en);

  a_r8_end_inside_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> xfer_ack);

  a_r8_ack_is_byte_access: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (mem_valid && mem_byte));

  a_r9_release_after_count_put: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(put_cnt_hs));

  a_r10_done_rise_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !chan_en);
endmodule

bind dma_desc_channel dma_desc_channel_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_byte  (mem_byte),
  .mem_addr  (mem_addr),
  .xfer_ack  (xfer_ack),
  .xfer_end  (xfer_end),
  .chan_en   (chan_en),
  .done      (done),
  .put_cnt_hs(put_cnt_hs)
);

// File: tb/test_dma_desc_channel.sv
module test_dma_desc_channel;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_set = 0, done_clr = 0, burst_mode = 0, req_active_low = 0, irq_en = 0;
  logic [1:0] src_mode = 0, dst_mode = 0;
  logic [AW-1:0] desc_base = '0;
  logic req_in = 0;
  logic bus_req, bus_gnt = 0;
  logic mem_valid, mem_we, mem_byte;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;
  logic xfer_ack, xfer_end, chan_en, done, irq;
  logic gnt_allow = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  dma_desc_channel i_dma_desc_channel (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .done_clr(done_clr),
    .burst_mode(burst_mode), .req_active_low(req_active_low), .irq_en(irq_en),
    .src_mode(src_mode), .dst_mode(dst_mode), .desc_base(desc_base),
    .req_in(req_in), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .xfer_ack(xfer_ack), .xfer_end(xfer_end),
    .chan_en(chan_en), .done(done), .irq(irq)
  );

  // CPU side: grant follows request one cycle later unless withheld
  always @(negedge clk) bus_gnt <= bus_req && gnt_allow;

  // Byte memory model, little-endian words
  logic [7:0] mem [256];
  wire  [7:0] ma = mem_addr[7:0];
  always_comb begin
    if (mem_byte) mem_rdata = {24'h0, mem[ma]};
    else          mem_rdata = {mem[ma + 8'd3], mem[ma + 8'd2], mem[ma + 8'd1], mem[ma]};
  end
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && mem_we) begin
      if (mem_byte) mem[ma] <= mem_wdata[7:0];
      else begin
        mem[ma]        <= mem_wdata[7:0];
        mem[ma + 8'd1] <= mem_wdata[15:8];
        mem[ma + 8'd2] <= mem_wdata[23:16];
        mem[ma + 8'd3] <= mem_wdata[31:24];
      end
    end
  end

  typedef struct {
    logic        we;
    logic        bt;
    logic [31:0] addr;
    logic [31:0] data;
    logic        last;
    string       tag;
  } acc_t;
  acc_t expq[$];

  int nchk = 0;
  int nfail = 0;
  int wr_seen = 0;

  function automatic logic [7:0] pat(logic [31:0] a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic logic steps(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction
  function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] m);
    if (m == 2'b01) return a + 1;
    if (m == 2'b10) return a - 1;
    return a;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic we, logic bt, logic [31:0] a, logic [31:0] d, logic last, string tag);
    acc_t e;
    e.we = we; e.bt = bt; e.addr = a; e.data = d; e.last = last; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic put_desc(logic [7:0] base, logic [31:0] s, logic [31:0] d, logic [31:0] c);
    for (int i = 0; i < 4; i++) begin
      mem[base + 8'(i)]      = s[8*i +: 8];
      mem[base + 8'(4 + i)]  = d[8*i +: 8];
      mem[base + 8'(8 + i)]  = c[8*i +: 8];
    end
  endtask

  // Driver: expected access stream of one tenure
  task automatic plan(logic [31:0] base, logic [31:0] s, logic [31:0] d, int cnt, int n,
                      logic [1:0] sm, logic [1:0] dm);
    logic [31:0] sa, da;
    sa = s; da = d;
    push(0, 0, base,     0, 0, "R4");
    push(0, 0, base + 4, 0, 0, "R4");
    push(0, 0, base + 8, 0, 0, "R4");
    for (int i = 0; i < n; i++) begin
      push(0, 1, sa, 0, (cnt - i) == 1, "R5");
      push(1, 1, da, {24'h0, pat(sa)}, (cnt - i) == 1, "R5");
      sa = nxt(sa, sm);
      da = nxt(da, dm);
    end
    if (steps(sm)) push(1, 0, base,     sa, 0, "R9");
    if (steps(dm)) push(1, 0, base + 4, da, 0, "R9");
    push(1, 0, base + 8, 32'(cnt - n), 0, "R9");
  endtask

  // Monitor: compares every accepted access against the queue
  always begin : mon
    acc_t e;
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we && mem_byte) wr_seen++;
      if (expq.size() == 0) begin
        chk(0, "R4", "unexpected access addr", mem_addr, 0);
      end else begin
        e = expq.pop_front();
        chk(mem_we == e.we && mem_byte == e.bt, e.tag, "access kind", {30'h0, mem_we, mem_byte}, {30'h0, e.we, e.bt});
        chk(mem_addr == e.addr, e.tag, "address", mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
        if (e.bt) begin
          chk(xfer_ack == 1'b1, "R8", "xfer_ack", {31'h0, xfer_ack}, 1);
          chk(xfer_end == e.last, "R8", "xfer_end", {31'h0, xfer_end}, {31'h0, e.last});
        end else begin
          chk(xfer_ack == 1'b0, "R8", "xfer_ack on word access", {31'h0, xfer_ack}, 0);
        end
      end
    end
  end

  task automatic drain(string tag);
    int t;
    t = 0;
    while ((expq.size() != 0 || bus_req) && t < 3000) begin
      tick(1);
      t++;
    end
    tick(3);
    chk(expq.size() == 0, tag, "accesses left over", expq.size(), 0);
  endtask

  task automatic arm();
    arm_set = 1; tick(1); arm_set = 0;
  endtask

  task automatic burst_kick();
    int t;
    req_in = ~req_active_low;
    t = 0;
    while (!bus_req && t < 50) begin tick(1); t++; end
    req_in = req_active_low;
  endtask

  task automatic run_all();
    int highs;
    logic [AW-1:0] held;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    chk({bus_req, mem_valid, xfer_ack, xfer_end, chan_en, done, irq} == 7'b0, "R1",
        "outputs after reset", {25'h0, bus_req, mem_valid, xfer_ack, xfer_end, chan_en, done, irq}, 0);

    // R2: request while not armed
    req_in = 1; highs = 0;
    for (int i = 0; i < 20; i++) begin tick(1); if (bus_req) highs++; end
    chk(highs == 0, "R2", "bus_req while disarmed", highs, 0);
    req_in = 0;

    // R2 polarity, then R6 burst inc/inc count 4
    put_desc(8'hC0, 32'h10, 32'h80, 4);
    desc_base = 32'hC0; burst_mode = 1; src_mode = 2'b01; dst_mode = 2'b01;
    irq_en = 1; req_active_low = 1; req_in = 1;
    tick(3);
    arm();
    highs = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (bus_req) highs++; end
    chk(highs == 0, "R2", "bus_req with inactive low-level request", highs, 0);
    chk(chan_en == 1, "R2", "chan_en after arm", {31'h0, chan_en}, 1);
    plan(32'hC0, 32'h10, 32'h80, 4, 4, 2'b01, 2'b01);
    burst_kick();
    drain("R6");
    chk(done == 1, "R10", "done after count exhausted", {31'h0, done}, 1);
    chk(chan_en == 0, "R10", "chan_en after count exhausted", {31'h0, chan_en}, 0);
    chk(irq == 1, "R10", "irq with irq_en", {31'h0, irq}, 1);
    req_active_low = 0; req_in = 0;
    tick(10);
    chk(done == 1, "R10", "done sticky", {31'h0, done}, 1);
    done_clr = 1; tick(1); done_clr = 0; tick(1);
    chk(done == 0 && irq == 0, "R10", "done/irq after clear", {30'h0, done, irq}, 0);

    // R3: fixed src, decrementing dst, grant withheld and memory stalled
    put_desc(8'hD0, 32'h20, 32'h9F, 3);
    desc_base = 32'hD0; src_mode = 2'b00; dst_mode = 2'b10; irq_en = 0;
    arm();
    plan(32'hD0, 32'h20, 32'h9F, 3, 3, 2'b00, 2'b10);
    burst_kick();
    while (expq.size() > 6) tick(1);
    gnt_allow = 0;
    tick(2);
    highs = expq.size();
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk(mem_valid == 0, "R3", "access without grant", {31'h0, mem_valid}, 0);
      chk(bus_req == 1, "R3", "bus_req held while waiting", {31'h0, bus_req}, 1);
    end
    chk(expq.size() == highs, "R3", "progress without grant", expq.size(), highs);
    gnt_allow = 1;
    while (expq.size() > 3) tick(1);
    mem_ready = 0;
    tick(1);
    held = mem_addr;
    tick(2);
    chk(mem_addr == held, "R3", "stalled address", mem_addr, held);
    mem_ready = 1;
    drain("R3");
    chk(done == 1 && irq == 0, "R10", "done set, irq masked", {30'h0, done, irq}, 2);
    done_clr = 1; tick(1); done_clr = 0;

    // R7: continuous, decrementing src, fixed dst, request removed after 3rd read
    put_desc(8'hE0, 32'h3F, 32'hA0, 6);
    desc_base = 32'hE0; burst_mode = 0; src_mode = 2'b10; dst_mode = 2'b00;
    arm();
    plan(32'hE0, 32'h3F, 32'hA0, 6, 3, 2'b10, 2'b00);
    wr_seen = 0;
    req_in = 1;
    while (wr_seen < 2) tick(1);
    tick(1);
    mem_ready = 0; req_in = 0;
    tick(6);
    mem_ready = 1;
    drain("R7");
    chk(done == 0, "R10", "done after partial tenure", {31'h0, done}, 0);
    chk(chan_en == 1, "R10", "chan_en after partial tenure", {31'h0, chan_en}, 1);
    highs = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (bus_req) highs++; end
    chk(highs == 0, "R7", "bus_req with request removed", highs, 0);
    plan(32'hE0, 32'h3C, 32'hA0, 3, 3, 2'b10, 2'b00);
    req_in = 1;
    drain("R7");
    req_in = 0;
    chk(done == 1 && chan_en == 0, "R10", "resumed tenure finished", {30'h0, done, chan_en}, 2);
    done_clr = 1; tick(1); done_clr = 0;

    // R5: reserved src mode 11 holds, dst increments, burst count 2
    put_desc(8'hF0, 32'h50, 32'hB0, 2);
    desc_base = 32'hF0; burst_mode = 1; src_mode = 2'b11; dst_mode = 2'b01;
    arm();
    plan(32'hF0, 32'h50, 32'hB0, 2, 2, 2'b11, 2'b01);
    burst_kick();
    drain("R5");
    chk(mem[8'hB1] == pat(32'h50), "R5", "held source copied twice", {24'h0, mem[8'hB1]}, {24'h0, pat(32'h50)});
    done_clr = 1; tick(1); done_clr = 0;

    // R11: zero count
    put_desc(8'hC0, 32'h60, 32'hB8, 0);
    desc_base = 32'hC0; src_mode = 2'b01; dst_mode = 2'b01;
    arm();
    plan(32'hC0, 32'h60, 32'hB8, 0, 0, 2'b01, 2'b01);
    burst_kick();
    drain("R11");
    chk(done == 1 && chan_en == 0, "R11", "finish on zero count", {30'h0, done, chan_en}, 2);
    chk(mem[8'hB8] == pat(32'hB8), "R11", "destination untouched", {24'h0, mem[8'hB8]}, {24'h0, pat(32'hB8)});
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule